// File: doc/BRIEF.md
# Coast Window Generator

This block drives a single coast flag that frames every vertical sync pulse. A horizontal-timing PLL downstream holds its phase while the flag is high, so the equalization pulses around vertical sync cannot pull it. Two 8-bit controls set the size of the window in whole line periods. One sets how many lines before the vertical sync the window opens. The other sets how many lines after the vertical sync it stays open. With both controls at zero, the window is the vertical sync pulse alone.

To open the window ahead of a vertical sync, the block counts horizontal sync leading edges from one vertical sync leading edge to the next. It keeps that count as the frame length. It raises coast once the running line count reaches the frame length minus the pre-coast value. The prediction is only trusted once a frame length has been measured, or once the measured length has repeated after a change. Until then only the vertical sync part and the post-coast part of the window are produced. A single filter-select input switches a glitch filter in or out on both sync paths together, so that the two paths always have the same delay.

Top module: `coast_window_gen`

## Requirements
- R1: While reset is held, and after reset until the first vertical sync arrives, coast is 0.
- R2: Coast is 1 during the whole vertical sync pulse, delayed by the block's pipeline latency.
- R3: With pre-coast and post-coast both 0, coast is 1 only for the vertical sync interval. With a sync 3 lines wide, exactly 3 line mid-points see coast high.
- R4: Post-coast loads the control value at the vertical sync falling edge. It decrements on each later horizontal sync leading edge and drops coast on the edge where it reaches 0, so coast stays high for that many extra lines.
- R5: With a stable frame length L and pre-coast value P < L, coast rises P lines before the vertical sync leading edge, covering lines L-P through L-1 of the frame.
- R6: The frame length is the number of horizontal sync leading edges between two consecutive vertical sync leading edges. The line counter restarts from 0 at every vertical sync leading edge.
- R7: After reset, pre-coast is suppressed until a vertical sync leading edge has closed one complete measured frame.
- R8: When a measured frame length differs from the stored one, pre-coast is suppressed until a frame of the same new length has been measured again.
- R9: A pre-coast value of L or more is treated as L-1, so the line on which the vertical sync rises (line count 0) is never covered by pre-coast.
- R10: The filter select (filt_en) acts on both sync paths at once. When it is 1, a level lasting fewer than 4 clock cycles on either input is ignored. When it is 0, every pulse is passed on.
- R11: With the filter off, coast follows a vertical sync change on the third rising clock edge at which the new level is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, active high, already synchronized |
| vsync_in | input | 1 | Vertical sync, active high, already synchronized |
| filt_en | input | 1 | 1 puts the glitch filter on both sync paths, 0 bypasses it on both |
| pre_lines | input | 8 | Lines of coast before the vertical sync leading edge |
| post_lines | input | 8 | Lines of coast after the vertical sync trailing edge |
| coast | output | 1 | Coast flag |

## Verification
A wrong line count or a wrong stored frame length appears at the port one frame later. The pre-coast window then opens on the wrong line, or not at all, and the number of line mid-points with coast high differs from P plus the sync width plus the post count. A validity flag that is set or cleared at the wrong moment shows up in the first frame after reset or after a length change: pre-coast appears or is missing in that frame. A wrong post-coast counter changes where coast falls after the sync, already in the same frame. A filter that is wrong on one path shifts one sync stream against the other, so a short glitch either changes the measured length or leaves it untouched. The per-clock reference model catches any single-cycle difference in the edge on which coast moves.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

  // Sync path indices inside the filter array
  localparam int PATH_HS   = 0;
  localparam int PATH_VS   = 1;
  localparam int NUM_PATHS = 2;

  // Common arithmetic width for window arithmetic
  localparam int ARITH_W = 16;

  typedef logic [ARITH_W-1:0] arith_t;

  // Effective pre-coast value: never reaches the frame length, so the
  // window cannot reach back to line count 0.
  function automatic arith_t clamp_pre(input arith_t pre, input arith_t len);
    arith_t res;
    if (len <= arith_t'(1))
      res = '0;
    else if (pre >= len)
      res = len - arith_t'(1);
    else
      res = pre;
    return res;
  endfunction

  // True when the running line count lies inside the predicted window.
  function automatic logic in_pre_window(input arith_t line, input arith_t len,
                                         input arith_t peff);
    logic hit;
    if (peff == '0)
      hit = 1'b0;
    else
      hit = (line >= (len - peff));
    return hit;
  endfunction

endpackage

// File: rtl/cwg_sync_filter.sv
module cwg_sync_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic filt_en,
  input  logic raw,
  output logic level,
  output logic level_d
);

  localparam int CNT_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_LEN - 1);

  logic             stage_q;
  logic             level_q;
  logic             level_d_q;
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= 1'b0;
      level_q   <= 1'b0;
      level_d_q <= 1'b0;
      run_cnt   <= '0;
    end else begin
      stage_q   <= raw;
      level_d_q <= level_q;
      if (!filt_en) begin
        level_q <= stage_q;
        run_cnt <= '0;
      end else if (stage_q == level_q) begin
        run_cnt <= '0;
      end else if (run_cnt == CNT_MAX) begin
        level_q <= stage_q;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  assign level   = level_q;
  assign level_d = level_d_q;

  // R10
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(filt_en) && (level_q != $past(level_q))) |-> ($past(run_cnt) == CNT_MAX));

  // R10
  filt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> (level_q == $past(stage_q)));

endmodule

// File: rtl/cwg_frame_meter.sv
module cwg_frame_meter #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_rise,
  input  logic              vs_rise,
  output logic [LINE_W-1:0] line_cnt,
  output logic [LINE_W-1:0] frame_len,
  output logic              len_valid
);

  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] len_q;
  logic              valid_q;
  logic              seen_q;
  logic              have_q;
  logic [LINE_W-1:0] line_inc;
  logic [LINE_W-1:0] captured;

  assign line_inc = (line_q == LINE_MAX) ? line_q : line_q + 1'b1;
  assign captured = hs_rise ? line_inc : line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      len_q   <= '0;
      valid_q <= 1'b0;
      seen_q  <= 1'b0;
      have_q  <= 1'b0;
    end else if (vs_rise) begin
      line_q <= '0;
      seen_q <= 1'b1;
      if (seen_q) begin
        valid_q <= have_q ? (captured == len_q) : 1'b1;
        have_q  <= 1'b1;
        len_q   <= captured;
      end
    end else if (hs_rise) begin
      line_q <= line_inc;
    end
  end

  assign line_cnt  = line_q;
  assign frame_len = len_q;
  assign len_valid = valid_q;

  // R6
  line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (line_q == '0));

  // R8
  valid_at_vs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q != $past(valid_q)) |-> $past(vs_rise));

  // R7
  first_vs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise && !seen_q) |=> !valid_q);

endmodule

// File: rtl/cwg_post_timer.sv
module cwg_post_timer #(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_rise,
  input  logic              vs_rise,
  input  logic              vs_fall,
  input  logic [CTRL_W-1:0] post_len,
  output logic              post_busy
);

  logic [CTRL_W-1:0] post_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_cnt <= '0;
    end else if (vs_rise) begin
      post_cnt <= '0;
    end else if (vs_fall) begin
      post_cnt <= post_len;
    end else if (hs_rise && (post_cnt != '0)) begin
      post_cnt <= post_cnt - 1'b1;
    end
  end

  assign post_busy = (post_cnt != '0);

  // R4
  post_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_fall && !vs_rise) |=> (post_cnt == $past(post_len)));

  // R4
  post_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_cnt != $past(post_cnt)) |-> ($past(vs_fall) || $past(vs_rise) || $past(hs_rise)));

endmodule

// File: rtl/coast_window_gen.sv
module coast_window_gen
  import cwg_pkg::*;
#(
  parameter int CTRL_W   = 8,
  parameter int LINE_W   = 12,
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              filt_en,
  input  logic [CTRL_W-1:0] pre_lines,
  input  logic [CTRL_W-1:0] post_lines,
  output logic              coast
);

  logic [NUM_PATHS-1:0] raw_v;
  logic [NUM_PATHS-1:0] lvl_v;
  logic [NUM_PATHS-1:0] lvl_d_v;

  assign raw_v[PATH_HS] = hsync_in;
  assign raw_v[PATH_VS] = vsync_in;

  // One select drives both filters so the two paths keep equal delay.
  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    cwg_sync_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .filt_en (filt_en),
      .raw     (raw_v[p]),
      .level   (lvl_v[p]),
      .level_d (lvl_d_v[p])
    );
  end

  // Named edge events
  logic hs_rise;
  logic vs_rise;
  logic vs_fall;
  logic vs_lvl;

  assign hs_rise = lvl_v[PATH_HS] & ~lvl_d_v[PATH_HS];
  assign vs_rise = lvl_v[PATH_VS] & ~lvl_d_v[PATH_VS];
  assign vs_fall = ~lvl_v[PATH_VS] & lvl_d_v[PATH_VS];
  assign vs_lvl  = lvl_v[PATH_VS];

  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W-1:0] frame_len;
  logic              len_valid;

  cwg_frame_meter #(.LINE_W(LINE_W)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_rise   (hs_rise),
    .vs_rise   (vs_rise),
    .line_cnt  (line_cnt),
    .frame_len (frame_len),
    .len_valid (len_valid)
  );

  logic post_busy;

  cwg_post_timer #(.CTRL_W(CTRL_W)) u_post (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_rise   (hs_rise),
    .vs_rise   (vs_rise),
    .vs_fall   (vs_fall),
    .post_len  (post_lines),
    .post_busy (post_busy)
  );

  // Predicted pre-coast window
  arith_t pre_eff;
  logic   pre_hit;
  logic   coast_next;
  logic   coast_q;

  assign pre_eff    = clamp_pre(arith_t'(pre_lines), arith_t'(frame_len));
  assign pre_hit    = len_valid && in_pre_window(arith_t'(line_cnt), arith_t'(frame_len), pre_eff);
  assign coast_next = vs_lvl | post_busy | pre_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coast_q <= 1'b0;
    else        coast_q <= coast_next;
  end

  assign coast = coast_q;

  // R2
  vs_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_lvl |=> coast_q);

  // R9
  line0_nopre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cnt == '0) |-> !pre_hit);

  // R7
  pre_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coast_q && !$past(vs_lvl) && !$past(post_busy)) |-> $past(len_valid));

endmodule

// File: tb/test_coast_window_gen.sv
module test_coast_window_gen;

  localparam int LINE_CYC = 20;
  localparam int HS_W     = 6;
  localparam int SAMPLE   = 15;
  localparam int FILT     = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs = 1'b0;
  logic       vs = 1'b0;
  logic       en = 1'b0;
  logic [7:0] pre = 8'd0;
  logic [7:0] post = 8'd0;
  logic       coast;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  coast_window_gen i_coast_window_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsync_in   (hs),
    .vsync_in   (vs),
    .filt_en    (en),
    .pre_lines  (pre),
    .post_lines (post),
    .coast      (coast)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model, updated once per rising edge
  int m_r[2], m_f[2], m_p[2], m_c[2];
  int m_line, m_len, m_valid, m_seen, m_have, m_post, m_coast;

  function automatic int m_prehit(int line, int len, int valid, int pv);
    int pe;
    if (valid == 0 || len <= 1) return 0;
    pe = (pv >= len) ? len - 1 : pv;
    if (pe == 0) return 0;
    return (line >= len - pe) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int hr, vr, vf, nc, cap, rawv;
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin m_r[p] = 0; m_f[p] = 0; m_p[p] = 0; m_c[p] = 0; end
      m_line = 0; m_len = 0; m_valid = 0; m_seen = 0; m_have = 0; m_post = 0; m_coast = 0;
    end else begin
      hr = (m_f[0] == 1 && m_p[0] == 0) ? 1 : 0;
      vr = (m_f[1] == 1 && m_p[1] == 0) ? 1 : 0;
      vf = (m_f[1] == 0 && m_p[1] == 1) ? 1 : 0;
      nc = (m_f[1] != 0 || m_post != 0 || m_prehit(m_line, m_len, m_valid, int'(pre)) != 0) ? 1 : 0;
      if (vr != 0) begin
        cap = m_line + hr;
        if (m_seen != 0) begin
          m_valid = (m_have != 0) ? ((cap == m_len) ? 1 : 0) : 1;
          m_have = 1;
          m_len = cap;
        end
        m_seen = 1;
        m_line = 0;
      end else if (hr != 0 && m_line < 4095) begin
        m_line = m_line + 1;
      end
      if (vr != 0) m_post = 0;
      else if (vf != 0) m_post = int'(post);
      else if (hr != 0 && m_post > 0) m_post = m_post - 1;
      for (int p = 0; p < 2; p++) begin
        rawv = (p == 0) ? int'(hs) : int'(vs);
        m_p[p] = m_f[p];
        if (!en) begin m_f[p] = m_r[p]; m_c[p] = 0; end
        else if (m_r[p] == m_f[p]) m_c[p] = 0;
        else if (m_c[p] == FILT - 1) begin m_f[p] = m_r[p]; m_c[p] = 0; end
        else m_c[p] = m_c[p] + 1;
        m_r[p] = rawv;
      end
      m_coast = nc;
    end
  end

  // Per-clock comparison against the model (R2 R4 R5)
  always @(negedge clk) begin
    if (!done) chk(coast === m_coast[0], "R5 model compare", int'(coast), m_coast);
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; hs = 1'b0; vs = 1'b0;
    repeat (3) @(negedge clk);
    chk(coast === 1'b0, "R1 reset", int'(coast), 0);
    rst_n = 1'b1;
  endtask

  task automatic run_frame(input int lines, input int vsw, input int ghs, input int gvs,
                           output int hi, output int l0);
    hi = 0; l0 = 0;
    for (int ln = 0; ln < lines; ln++) begin
      for (int c = 0; c < LINE_CYC; c++) begin
        int t;
        @(negedge clk);
        if (c == SAMPLE) begin
          if (coast) hi++;
          if (ln == 0) l0 = int'(coast);
        end
        t = ln * LINE_CYC + c;
        hs = (c < HS_W) || (ln == ghs && c >= 10 && c < 12);
        vs = (t >= 5 && t < 5 + vsw) || (ln == gvs && c >= 10 && c < 12);
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int hi, l0;
    // R11 latency and R1 idle
    do_reset();
    run_frame(4, 0, -1, -1, hi, l0);
    chk(hi == 0, "R1 idle no vsync", hi, 0);
    @(negedge clk); vs = 1'b1;
    @(negedge clk); chk(coast === 1'b0, "R11 rise edge1", int'(coast), 0);
    @(negedge clk); chk(coast === 1'b0, "R11 rise edge2", int'(coast), 0);
    @(negedge clk); chk(coast === 1'b1, "R11 rise edge3", int'(coast), 1);
    vs = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(coast === 1'b1, "R11 fall edge2", int'(coast), 1);
    @(negedge clk); chk(coast === 1'b0, "R11 fall edge3", int'(coast), 0);

    // R3 and R2: plain sync window
    do_reset();
    for (int f = 0; f < 3; f++) begin
      run_frame(16, 60, -1, -1, hi, l0);
      if (f > 0) chk(hi == 3, "R3 only vsync lines", hi, 3);
      chk(l0 == 1, "R2 coast during vsync", l0, 1);
    end
    // R4 post-coast
    post = 8'd2;
    run_frame(16, 60, -1, -1, hi, l0);
    chk(hi == 5, "R4 post lines", hi, 5);
    // R5 and R6 pre-coast from measured length
    pre = 8'd4;
    run_frame(16, 60, -1, -1, hi, l0);
    chk(hi == 9, "R5 pre lines", hi, 9);
    run_frame(16, 60, -1, -1, hi, l0);
    chk(hi == 9, "R6 stable length", hi, 9);
    // R8 shortened frames
    run_frame(12, 60, -1, -1, hi, l0);
    chk(hi == 5, "R8 first short frame", hi, 5);
    run_frame(12, 60, -1, -1, hi, l0);
    chk(hi == 5, "R8 changed length suppressed", hi, 5);
    run_frame(12, 60, -1, -1, hi, l0);
    chk(hi == 9, "R8 recovered", hi, 9);

    // R7 after reset
    do_reset();
    run_frame(16, 60, -1, -1, hi, l0);
    chk(hi == 5, "R7 first frame no pre", hi, 5);
    run_frame(16, 60, -1, -1, hi, l0);
    chk(hi == 9, "R7 second frame pre", hi, 9);

    // R9 clamp
    pre = 8'd200; post = 8'd0;
    do_reset();
    run_frame(16, 3, -1, -1, hi, l0);
    run_frame(16, 3, -1, -1, hi, l0);
    chk(hi == 15, "R9 clamped count", hi, 15);
    chk(l0 == 0, "R9 line0 open", l0, 0);
    run_frame(16, 3, -1, -1, hi, l0);
    chk(hi == 15, "R9 clamped again", hi, 15);

    // R10 bypass passes a short hsync pulse
    pre = 8'd4; post = 8'd2; en = 1'b0;
    do_reset();
    run_frame(16, 60, -1, -1, hi, l0);
    run_frame(16, 60, -1, -1, hi, l0);
    run_frame(16, 60, 5, -1, hi, l0);
    run_frame(16, 60, -1, -1, hi, l0);
    chk(hi == 5, "R10 bypass glitch counted", hi, 5);

    // R10 filter removes short pulses on both paths
    en = 1'b1;
    do_reset();
    run_frame(16, 60, -1, -1, hi, l0);
    run_frame(16, 60, -1, -1, hi, l0);
    chk(hi == 9, "R10 filtered window", hi, 9);
    run_frame(16, 60, 5, 8, hi, l0);
    chk(hi == 9, "R10 glitch frame", hi, 9);
    run_frame(16, 60, -1, -1, hi, l0);
    chk(hi == 9, "R10 after glitches", hi, 9);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule